// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte register that sits at a single I/O port address. Software uses it to ask for a system reset and to choose which kind of reset it wants. When a write has the trigger bit set, the block raises a one-cycle request for an external reset sequencer. That write does not change the stored byte. Any other write to the port keeps only the reset-type bit and clears every other bit. A read of the port returns the stored byte.

The I/O interface is simple. There are separate write and read strobes, one address bus and one byte in each direction. The block decodes only its own port address, so accesses to any other address have no effect on it. The reset sequencer is outside this block and watches `rst_req_o`.

Top module: `rst_ctrl_port`

## Requirements
- R1: After the asynchronous reset is released, the stored byte is 0x00 and `rst_req_o` is low.
- R2: A write to the port with bit 2 clear stores bit 1 of the written byte. Every other bit of the stored byte becomes 0.
- R3: A write to the port with bit 2 set drives `rst_req_o` high for exactly the one cycle that follows the clock edge that accepts the write.
- R4: A write to the port with bit 2 set leaves the stored byte unchanged, whatever the other bits of the written byte are.
- R5: In a cycle with `rd_i` high and `addr_i` equal to the port address, `rdata_o` shows the stored byte as it was before that cycle's edge. In every other cycle, `rdata_o` is 0x00.
- R6: A write to any other address changes neither the stored byte nor `rst_req_o`, even when bit 2 is set.
- R7: Trigger writes in back-to-back cycles each produce a request cycle, so `rst_req_o` stays high for as many consecutive cycles as there were trigger writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (16) | I/O address of the access |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0x00 when the port is not being read |
| rst_req_o | output | 1 | Registered one-cycle system reset request |

## Verification
A corrupted type bit appears on the very next read of the port, because reads are combinational from the stored byte. A trigger write that wrongly updates storage is also caught by that read. A request that is missing, stretched or spurious appears on `rst_req_o` one cycle after the write edge. The bench therefore compares both outputs in every cycle. A decode fault at the wrong address appears either as a request pulse in the next cycle or as a changed value on the following read of the real port.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned TRIG_BIT = 2;   // write-only action bit
  localparam int unsigned TYPE_BIT = 1;   // held reset-type bit
  localparam logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/rst_ctrl_decode.sv
module rst_ctrl_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TRIG_BIT = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_hit_o,
  output logic              store_o,
  output logic              trig_o
);
  logic hit;
  assign hit      = (addr_i == PORT_ADDR);
  assign rd_hit_o = rd_i && hit;
  assign trig_o   = wr_i && hit && wdata_i[TRIG_BIT];
  assign store_o  = wr_i && hit && !wdata_i[TRIG_BIT];
endmodule

// File: rtl/rst_ctrl_store.sv
module rst_ctrl_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TYPE_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] val_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (store_i) val_q <= wdata_i & KEEP_MASK;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rst_ctrl_pulse.sv
module rst_ctrl_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= trig_i;
  end

  assign req_o = req_q;
endmodule

// File: rtl/rst_ctrl_port.sv
module rst_ctrl_port
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter logic [P_ADDR_W-1:0] P_PORT_ADDR = PORT_ADDR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rst_req_o
);
  logic  rd_hit, store, trig;
  byte_t held;

  rst_ctrl_decode #(
    .ADDR_W(P_ADDR_W), .PORT_ADDR(P_PORT_ADDR),
    .DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT)
  ) u_decode (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .rd_hit_o(rd_hit), .store_o(store), .trig_o(trig)
  );

  rst_ctrl_store #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .store_i(store),
    .wdata_i(wdata_i), .val_o(held)
  );

  rst_ctrl_pulse u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .req_o(rst_req_o)
  );

  assign rdata_o = rd_hit ? held : '0;
endmodule

// File: rtl/rst_ctrl_port_chk.sv
module rst_ctrl_port_chk
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter logic [P_ADDR_W-1:0] P_PORT_ADDR = PORT_ADDR
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [P_ADDR_W-1:0] addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                rst_req_o,
  input logic [DATA_W-1:0]   held
);
  logic at_port, trig_wr, plain_wr;
  assign at_port  = (addr_i == P_PORT_ADDR);
  assign trig_wr  = wr_i && at_port && wdata_i[TRIG_BIT];
  assign plain_wr = wr_i && at_port && !wdata_i[TRIG_BIT];

  AST_ONLY_TYPE_BIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held & ~(DATA_W'(1) << TYPE_BIT)) == '0); // R2
  AST_PLAIN_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_wr |=> held[TYPE_BIT] == $past(wdata_i[TYPE_BIT])); // R2
  AST_REQ_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr |=> rst_req_o); // R3
  AST_REQ_ONLY_FROM_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(trig_wr)); // R3
  AST_TRIG_KEEPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr |=> $stable(held)); // R4
  AST_READ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o == ((rd_i && at_port) ? held : '0)); // R5
  AST_MISS_KEEPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && at_port) |=> $stable(held)); // R6
endmodule

bind rst_ctrl_port rst_ctrl_port_chk #(
  .P_ADDR_W(P_ADDR_W), .P_PORT_ADDR(P_PORT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o), .held(held)
);

// File: tb/rst_ctrl_port_tb.sv
module rst_ctrl_port_tb;
  import rst_ctrl_pkg::*;

  localparam logic [ADDR_W-1:0] OTHER = 16'h0CF8;

  typedef struct {
    logic [7:0] rdata;
    logic       req;
    string      tag;
  } exp_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              wr_i = 1'b0;
  logic              rd_i = 1'b0;
  logic [7:0]        wdata_i = '0;
  logic [7:0]        rdata_o;
  logic              rst_req_o;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t q[$];
  logic [7:0] m_held = 8'h00;
  logic       m_prev_trig = 1'b0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  rst_ctrl_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o)
  );

  // One access per cycle, driven at the falling edge
  task automatic op(input logic wr, input logic rd, input logic [ADDR_W-1:0] a,
                    input logic [7:0] d, input string tag);
    exp_t e;
    logic hit, trig;
    @(negedge clk_i);
    wr_i = wr; rd_i = rd; addr_i = a; wdata_i = d;
    hit     = (a == PORT_ADDR);
    e.rdata = (rd && hit) ? m_held : 8'h00;
    e.req   = m_prev_trig;
    e.tag   = tag;
    q.push_back(e);
    trig = wr && hit && d[2];
    if (wr && hit && !d[2]) m_held = d & 8'h02;
    m_prev_trig = trig;
  endtask

  // Monitor: compare in the middle of the low phase
  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (rdata_o !== e.rdata) begin
          n_fail++;
          $display("FAIL %s rdata actual=%02h expected=%02h", e.tag, rdata_o, e.rdata);
        end
        n_run++;
        if (rst_req_o !== e.req) begin
          n_fail++;
          $display("FAIL %s rst_req actual=%0b expected=%0b", e.tag, rst_req_o, e.req);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    op(0, 1, PORT_ADDR, 8'h00, "R1");          // reset value read
    op(0, 0, PORT_ADDR, 8'h00, "R1");
    op(1, 0, PORT_ADDR, 8'hFB, "R2");          // bit2 clear, all else set
    op(0, 1, PORT_ADDR, 8'h00, "R2");          // expect 02
    op(1, 0, PORT_ADDR, 8'hFF, "R4");          // trigger, held stays 02
    op(0, 1, PORT_ADDR, 8'h00, "R3");          // pulse visible here
    op(0, 1, PORT_ADDR, 8'h00, "R3");          // pulse gone
    op(1, 0, PORT_ADDR, 8'h00, "R2");          // clear
    op(1, 0, PORT_ADDR, 8'h04, "R4");          // trigger with type bit 0
    op(0, 1, PORT_ADDR, 8'h00, "R4");          // expect 00
    op(1, 0, OTHER, 8'h02, "R6");              // wrong address store
    op(0, 1, PORT_ADDR, 8'h00, "R6");          // still 00
    op(1, 0, OTHER, 8'h06, "R6");              // wrong address trigger
    op(0, 1, OTHER, 8'h00, "R6");              // no req, rdata 0
    op(1, 0, PORT_ADDR, 8'h02, "R2");
    op(1, 1, PORT_ADDR, 8'h00, "R5");          // read shows old 02
    op(0, 1, PORT_ADDR, 8'h00, "R5");          // now 00
    op(1, 0, PORT_ADDR, 8'h02, "R2");
    op(0, 0, PORT_ADDR, 8'h00, "R5");          // no read -> 0
    op(1, 0, PORT_ADDR, 8'h04, "R7");
    op(1, 0, PORT_ADDR, 8'h06, "R7");
    op(1, 0, PORT_ADDR, 8'h04, "R7");
    op(0, 1, PORT_ADDR, 8'h00, "R7");          // third pulse, held 02
    op(0, 1, PORT_ADDR, 8'h00, "R7");          // ended
    op(0, 0, PORT_ADDR, 8'h00, "R3");
    repeat (2) @(negedge clk_i);
    #8;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule